// File: doc/BRIEF.md
# Multi-Channel Down-Counting Interval Timer

This block holds a small bank of down-counting timer channels behind a simple word-addressed register bus. Software writes an interval and a control word to each channel. The channel then counts down from that interval at a rate set by a per-channel power-of-two prescaler applied to an external tick pulse. Each channel runs either periodically, reloading its interval after it reaches zero, or as a one-shot that stops at zero.

When a channel's counter steps down to zero, a sticky status flag is set for that channel. One shared enable register masks the flags, and a single interrupt line carries the result. The live count can be read at any time, so software measures elapsed time as the difference between two reads. A channel loaded with an all-ones interval in periodic mode acts as a free-running down counter.

Starting and stopping pass through a two-stage synchroniser clocked by the tick pulse. A channel therefore begins counting two ticks after it is enabled, and it can keep counting for up to two ticks after it is disabled.

Top module: `mmio_dtimer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Address map:
  - interrupt enable at 0x00, with bit n for channel n;
  - status at 0x04;
  - channel n's control at 0x10·n+0x10, interval at 0x10·n+0x14 and live count at 0x10·n+0x18.
  - Any other offset reads 0.
  - A read returns its data on `bus_rdata` with `bus_rvalid` high in the cycle after the strobe.
- R3: Control word layout:
  - bit 0 is enable;
  - bit 1 is load, which self-clears and always reads 0;
  - bits 3:2 are a stored clock-source select;
  - bits 6:4 are the prescaler code;
  - bit 7 selects one-shot (1) or periodic (0) mode.
- R4: A control write with bit 1 set copies the interval register into the counter on that clock edge.
- R5: The enable bit reaches the counter through two tick-clocked stages. After enable is set, the first two tick pulses do not count. After enable is cleared, at most two more counting steps occur.
- R6: While running, the counter decrements once every 2^code tick pulses, for codes 0 to 7. Without a counting step it holds its value.
- R7: In periodic mode, the counting step taken while the counter is 0 reloads the interval. An all-ones interval therefore gives a free-running down counter.
- R8: In one-shot mode, the step that brings the counter to 0 clears the enable bit, and the counter stays at 0 afterwards.
- R9: A channel's status flag is set on the step that brings its counter from 1 to 0. Writing 1 to its status bit clears it. Writing 0 leaves it unchanged. The flag stays set while the channel is disabled.
- R10: `irq` is registered. One cycle after a change, it equals the OR over all channels of (status flag AND enable bit).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse from the timer source clock |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (8) | Byte address of the register |
| bus_wdata | input | CW (32) | Write data |
| bus_rdata | output | CW (32) | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| irq | output | 1 | Combined masked interrupt |

## Verification
Counting is driven with discrete tick pulses, so each expected count is exact. The bench runs four cases:
- Prescaler code 0 in periodic mode separates the two-tick start-up delay from the first decrement and from the reload at zero.
- Code 2 on a second channel shows that three idle ticks leave the count unchanged and the fourth decrements it, which separates a correct 2^code divider from a linear one.
- A one-shot run, set against the periodic run, shows the enable clearing and the count parking at zero.
- A disable in mid-count shows exactly two trailing steps.

Status writes of 0 and of 1, with the interrupt enable on and off, separate the sticky flag from the mask.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    // Register offsets (bytes)
    localparam int OFS_IEN    = 'h00;
    localparam int OFS_STAT   = 'h04;
    localparam int CH_CTL     = 'h0;
    localparam int CH_IVL     = 'h4;
    localparam int CH_CNT     = 'h8;

    // Stored part of a channel control word (load bit is not stored)
    typedef struct packed {
        logic       oneshot;
        logic [2:0] pre;
        logic [1:0] src;
        logic       en;
    } ctl_t;

    function automatic logic [7:0] ctl_view(input ctl_t c);
        return {c.oneshot, c.pre, c.src, 1'b0, c.en};
    endfunction

endpackage

// File: rtl/dtmr_prescale.sv
module dtmr_prescale #(
    parameter int PW = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick,
    input  logic [2:0] code,
    output logic       step
);
    logic [PW-1:0] pre_d, pre_q;
    logic [PW-1:0] mask;

    always_comb begin
        mask  = ~({PW{1'b1}} << code);
        step  = run & tick & ((pre_q & mask) == mask);
        pre_d = pre_q;
        if (!run)      pre_d = '0;
        else if (tick) pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
    import dtmr_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          ctl_we,
    input  logic          ivl_we,
    input  logic          flag_clr,
    input  logic [CW-1:0] wdata,
    output logic [7:0]    ctl_rd,
    output logic [CW-1:0] ivl_rd,
    output logic [CW-1:0] cnt_rd,
    output logic          flag,
    output logic          step
);
    typedef struct packed {
        ctl_t          ctl;
        logic [CW-1:0] ivl;
        logic [CW-1:0] cnt;
        logic [1:0]    sync;
        logic          flag;
    } ch_t;

    ch_t s_q, s_d;
    logic run;

    assign run = s_q.sync[1];

    dtmr_prescale #(.PW(7)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick),
        .code (s_q.ctl.pre),
        .step (step)
    );

    always_comb begin
        s_d = s_q;
        if (tick) s_d.sync = {s_q.sync[0], s_q.ctl.en};
        if (flag_clr) s_d.flag = 1'b0;
        if (step) begin
            if (s_q.cnt != '0) begin
                s_d.cnt = s_q.cnt - 1'b1;
                if (s_q.cnt == CW'(1)) begin
                    s_d.flag = 1'b1;
                    if (s_q.ctl.oneshot) s_d.ctl.en = 1'b0;
                end
            end else if (!s_q.ctl.oneshot) begin
                s_d.cnt = s_q.ivl;
            end else begin
                s_d.ctl.en = 1'b0;
            end
        end
        if (ivl_we) s_d.ivl = wdata;
        if (ctl_we) begin
            s_d.ctl.en      = wdata[0];
            s_d.ctl.src     = wdata[3:2];
            s_d.ctl.pre     = wdata[6:4];
            s_d.ctl.oneshot = wdata[7];
            if (wdata[1]) s_d.cnt = s_q.ivl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctl_rd = ctl_view(s_q.ctl);
    assign ivl_rd = s_q.ivl;
    assign cnt_rd = s_q.cnt;
    assign flag   = s_q.flag;
endmodule

// File: rtl/mmio_dtimer.sv
module mmio_dtimer
    import dtmr_pkg::*;
#(
    parameter int NCH = 2,
    parameter int CW  = 32,
    parameter int AW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [CW-1:0] bus_wdata,
    output logic [CW-1:0] bus_rdata,
    output logic          bus_rvalid,
    output logic          irq
);
    localparam int SW = AW - 4;

    typedef struct packed {
        logic [NCH-1:0] ien;
        logic [CW-1:0]  rdata;
        logic           rvalid;
        logic           irq;
    } top_t;

    top_t t_q, t_d;

    logic [NCH-1:0]         flag_v, step_v, cwe_v, iwe_v, ld_v, en_v, os_v;
    logic [NCH-1:0][7:0]    ctl_v;
    logic [NCH-1:0][CW-1:0] ivl_v, cnt_v;
    logic                   wr_hit, stat_we;
    logic [3:0]             sub;

    assign wr_hit  = bus_sel & bus_wr;
    assign sub     = bus_addr[3:0];
    assign stat_we = wr_hit && (bus_addr == AW'(OFS_STAT));

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic hit;
        assign hit      = (bus_addr[AW-1:4] == SW'(n + 1));
        assign cwe_v[n] = wr_hit & hit & (sub == 4'(CH_CTL));
        assign iwe_v[n] = wr_hit & hit & (sub == 4'(CH_IVL));
        assign ld_v[n]  = cwe_v[n] & bus_wdata[1];
        assign en_v[n]  = ctl_v[n][0];
        assign os_v[n]  = ctl_v[n][7];

        dtmr_channel #(.CW(CW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .ctl_we  (cwe_v[n]),
            .ivl_we  (iwe_v[n]),
            .flag_clr(stat_we & bus_wdata[n]),
            .wdata   (bus_wdata),
            .ctl_rd  (ctl_v[n]),
            .ivl_rd  (ivl_v[n]),
            .cnt_rd  (cnt_v[n]),
            .flag    (flag_v[n]),
            .step    (step_v[n])
        );
    end

    always_comb begin
        t_d        = t_q;
        t_d.rvalid = bus_sel & ~bus_wr;
        t_d.rdata  = '0;
        if (bus_addr == AW'(OFS_IEN))  t_d.rdata[NCH-1:0] = t_q.ien;
        if (bus_addr == AW'(OFS_STAT)) t_d.rdata[NCH-1:0] = flag_v;
        for (int n = 0; n < NCH; n++) begin
            if (bus_addr[AW-1:4] == SW'(n + 1)) begin
                case (sub)
                    4'(CH_CTL): t_d.rdata = CW'(ctl_v[n]);
                    4'(CH_IVL): t_d.rdata = ivl_v[n];
                    4'(CH_CNT): t_d.rdata = cnt_v[n];
                    default:    ;
                endcase
            end
        end
        if (!(bus_sel & ~bus_wr)) t_d.rdata = '0;
        if (wr_hit && bus_addr == AW'(OFS_IEN)) t_d.ien = bus_wdata[NCH-1:0];
        t_d.irq = |(flag_v & t_q.ien);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign bus_rdata  = t_q.rdata;
    assign bus_rvalid = t_q.rvalid;
    assign irq        = t_q.irq;
endmodule

// File: rtl/dtmr_check.sv
module dtmr_check #(
    parameter int NCH = 2,
    parameter int CW  = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   irq,
    input logic [NCH-1:0]         ien,
    input logic [NCH-1:0]         flag_v,
    input logic [NCH-1:0]         step_v,
    input logic [NCH-1:0]         cwe_v,
    input logic [NCH-1:0]         ld_v,
    input logic [NCH-1:0]         en_v,
    input logic [NCH-1:0]         os_v,
    input logic [NCH-1:0][CW-1:0] cnt_v,
    input logic [NCH-1:0][CW-1:0] ivl_v
);
    p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|(flag_v & ien)));

    for (genvar n = 0; n < NCH; n++) begin : g_chk
        p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ld_v[n] |=> cnt_v[n] == $past(ivl_v[n]));
        p_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (step_v[n] && !ld_v[n] && cnt_v[n] != '0) |=> cnt_v[n] == $past(cnt_v[n]) - 1'b1);
        p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!step_v[n] && !ld_v[n]) |=> $stable(cnt_v[n]));
        p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (step_v[n] && !ld_v[n] && !os_v[n] && cnt_v[n] == '0) |=> cnt_v[n] == $past(ivl_v[n]));
        p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (step_v[n] && !ld_v[n] && cnt_v[n] == CW'(1)) |=> flag_v[n]);
        p_oneshot_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (step_v[n] && !cwe_v[n] && os_v[n] && cnt_v[n] == CW'(1)) |=> !en_v[n]);
    end
endmodule

bind mmio_dtimer dtmr_check #(.NCH(NCH), .CW(CW)) u_dtmr_check (
    .clk   (clk),
    .rst_n (rst_n),
    .irq   (irq),
    .ien   (t_q.ien),
    .flag_v(flag_v),
    .step_v(step_v),
    .cwe_v (cwe_v),
    .ld_v  (ld_v),
    .en_v  (en_v),
    .os_v  (os_v),
    .cnt_v (cnt_v),
    .ivl_v (ivl_v)
);

// File: tb/mmio_dtimer_test.sv
module mmio_dtimer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        irq;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic [31:0] d;
        logic [7:0]  a;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    mmio_dtimer #(.NCH(2), .CW(32), .AW(8)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq(irq)
    );

    // monitor: pops the expected read and compares
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            tests++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R2 unexpected read data %h expected none", bus_rdata);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (bus_rdata !== e.d) begin
                    fails++;
                    $display("FAIL %s addr %h: got %h expected %h", e.tag, e.a, bus_rdata, e.d);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_t x;
        x.d = e; x.a = a; x.tag = tag;
        sb.push_back(x);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        tests++;
        if (irq !== e) begin
            fails++;
            $display("FAIL %s irq: got %b expected %b", tag, irq, e);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h00, 32'h0, "R1 ien");
        rd(8'h04, 32'h0, "R1 status");
        rd(8'h10, 32'h0, "R1 ctl0");
        rd(8'h24, 32'h0, "R1 ivl1");
        rd(8'h28, 32'h0, "R1 cnt1");
        chk_irq(1'b0, "R1");

        // R2 map and unmapped offsets
        rd(8'h0C, 32'h0, "R2 unmapped 0C");
        rd(8'h1C, 32'h0, "R2 unmapped 1C");
        rd(8'h30, 32'h0, "R2 unmapped 30");
        rd(8'hFC, 32'h0, "R2 unmapped FC");
        wr(8'h14, 32'd5);
        rd(8'h14, 32'd5, "R2 ivl0");
        rd(8'h24, 32'd0, "R2 ivl1 untouched");

        // R3 fields, R4 load without enable
        wr(8'h10, 32'h36);
        rd(8'h10, 32'h34, "R3 ctl0 readback, load reads 0");
        rd(8'h18, 32'd5, "R4 load copies interval");
        ticks(4);
        rd(8'h18, 32'd5, "R5 disabled channel holds");

        // periodic, code 0
        wr(8'h14, 32'd3);
        wr(8'h10, 32'h03);
        rd(8'h10, 32'h01, "R3 enable set, load cleared");
        rd(8'h18, 32'd3, "R4 loaded");
        ticks(2);
        rd(8'h18, 32'd3, "R5 two sync ticks no count");
        ticks(1);
        rd(8'h18, 32'd2, "R6 first decrement");
        ticks(2);
        rd(8'h18, 32'd0, "R6 reached zero");
        rd(8'h04, 32'h1, "R9 flag set at zero");
        chk_irq(1'b0, "R10 masked");
        wr(8'h00, 32'h1);
        chk_irq(1'b1, "R10 unmasked");
        rd(8'h00, 32'h1, "R2 ien readback");
        ticks(1);
        rd(8'h18, 32'd3, "R7 periodic reload");
        wr(8'h04, 32'h0);
        rd(8'h04, 32'h1, "R9 write 0 keeps flag");
        wr(8'h04, 32'h1);
        rd(8'h04, 32'h0, "R9 write 1 clears flag");
        chk_irq(1'b0, "R10 after clear");

        // disable mid-count
        wr(8'h10, 32'h00);
        ticks(1);
        rd(8'h18, 32'd2, "R5 trailing step 1");
        ticks(1);
        rd(8'h18, 32'd1, "R5 trailing step 2");
        ticks(2);
        rd(8'h18, 32'd1, "R5 stopped");

        // channel 1, prescaler code 2
        wr(8'h24, 32'd100);
        wr(8'h20, 32'h23);
        rd(8'h20, 32'h21, "R3 ctl1 readback");
        ticks(10);
        rd(8'h28, 32'd98, "R6 divide by 4");
        ticks(3);
        rd(8'h28, 32'd98, "R6 idle prescaled ticks");
        ticks(1);
        rd(8'h28, 32'd97, "R6 fourth tick steps");

        // channel 0 one-shot
        wr(8'h14, 32'd2);
        wr(8'h10, 32'h83);
        ticks(4);
        rd(8'h18, 32'd0, "R8 one-shot at zero");
        rd(8'h10, 32'h80, "R8 enable cleared");
        rd(8'h04, 32'h1, "R9 one-shot flag");
        chk_irq(1'b1, "R10 one-shot irq");
        ticks(3);
        rd(8'h18, 32'd0, "R8 stays at zero");
        rd(8'h04, 32'h1, "R9 flag held while disabled");
        rd(8'h28, 32'd96, "R6 channel 1 independent");

        // free-running all ones
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h20, 32'h03);
        rd(8'h28, 32'hFFFF_FFFF, "R7 all-ones load");
        ticks(1);
        rd(8'h28, 32'hFFFF_FFFE, "R7 free-run step");
        ticks(2);
        rd(8'h28, 32'hFFFF_FFFC, "R7 free-run continues");

        wr(8'h04, 32'h1);
        chk_irq(1'b0, "R10 final clear");

        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule